// File: doc/BRIEF.md
# Two-Wire Bus Repeated-Start Generator

This block produces a repeated-start condition on an open-drain two-wire serial bus (clock line and data line, each pulled high externally and only ever driven low by this block). When it is idle and no other bus event is running, a one-cycle request starts the sequence. The sequence pulls the clock low and releases the data line. It then releases the clock, holds both lines high for one baud period, and pulls the data line low while the clock stays high. After the final baud period the data line stays pulled low, ready for the first data bit.

Each timed phase begins from the line level the block samples through a two-flop synchronizer, not from the level it drives. A second device that stretches the clock therefore lengthens the sequence rather than breaking it. The block checks for a collision at two points: the data line seen low as the clock rises, and the clock seen low during the high-hold phase. On a collision it releases both lines and returns to idle without raising its completion pulse.

The states are `RS_IDLE`, `RS_SCL_DOWN`, `RS_SDA_UP`, `RS_SDA_WAIT`, `RS_SCL_UP`, `RS_HOLD_HIGH`, `RS_SDA_DOWN` and `RS_DONE`. The transitions are:
- idle to clock-down on an accepted request;
- clock-down to data-release when the clock is sampled low;
- data-release to clock-release on baud expiry if the data line is sampled high, otherwise to data-wait;
- data-wait to clock-release once the data line is sampled high;
- clock-release to high-hold when the clock is sampled high with the data line high, or to idle with a collision if the data line is low;
- high-hold to data-down on baud expiry, or to idle with a collision if the clock is sampled low;
- data-down to done on baud expiry;
- done to idle.

Top module: `i2c_rstart_seq`

## Requirements
- R1: A request on `rs_req_i` is accepted only when `busy_o` is 0 and `bus_active_i` is 0. A request made at any other time has no effect and is not remembered.
- R2: In the cycle after acceptance, `scl_pull_o` is 1 and `sda_pull_o` keeps its previous value. The data line is released only after the clock line is sampled low.
- R3: The baud period is `reload_i`+1 clock cycles. After data release the clock stays pulled low for exactly one baud period, and is then released because the data line reads high.
- R4: From the clock release (`scl_pull_o` falling) to `sda_pull_o` rising takes `reload_i`+4 cycles: 3 cycles to see the clock high through the synchronizer and state register, then one baud period with both lines high.
- R5: `sda_pull_o` stays 1 for one baud period (`reload_i`+1 cycles) before `done_irq_o` pulses for one cycle. After that pulse `busy_o` is 0, `scl_pull_o` is 0 and `sda_pull_o` remains 1.
- R6: `start_seen_o` sets when the sampled data line falls while the sampled clock line is high. With `reload_i` of 3 or more it is already 1 when `done_irq_o` pulses. It clears when a request is accepted.
- R7: If the data line is sampled low when the clock line is first sampled high after release, `collision_o` sets.
- R8: If the clock line is sampled low during the high-hold phase, before the data line is pulled low, `collision_o` sets.
- R9: On a collision, both pull outputs go to 0, `busy_o` goes to 0 and `done_irq_o` never pulses. `collision_o` stays 1 until the next accepted request clears it.
- R10: While another device holds the clock low after release, the block waits without flagging a collision. The R4 timing then counts from the release by that device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rs_req_i | input | 1 | One-cycle repeated-start request |
| bus_active_i | input | 1 | Another bus event is in progress; blocks acceptance |
| reload_i | input | BRG_W | Baud counter reload value (period = value + 1 cycles) |
| scl_i | input | 1 | Clock line level as seen on the bus |
| sda_i | input | 1 | Data line level as seen on the bus |
| scl_pull_o | output | 1 | 1 pulls the clock line low |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Sequence in progress |
| start_seen_o | output | 1 | Start condition observed on the sampled lines |
| done_irq_o | output | 1 | One-cycle completion pulse |
| collision_o | output | 1 | Bus collision detected (sticky until next acceptance) |

## Verification
The bench models both lines as open-drain wires that this block and an external agent can each pull low. It runs the sequence with the data line first released and then held low from an earlier start, which tells apart a design that releases the data line before the clock is sampled low. Phase lengths are measured at reload values of 3, 4, 5 and 7, so an off-by-one in the counter or a phase timed from the driven level instead of the sampled one shows up as a wrong cycle count. Three external interferences are applied: a stretched clock, which must delay the sequence without error; the data line forced low as the clock rises; and the clock forced low during the high-hold phase. These separate the two collision checks from legitimate waiting. Requests made while busy or while another event is active confirm that nothing is queued.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
    typedef enum logic [2:0] {
        RS_IDLE,
        RS_SCL_DOWN,
        RS_SDA_UP,
        RS_SDA_WAIT,
        RS_SCL_UP,
        RS_HOLD_HIGH,
        RS_SDA_DOWN,
        RS_DONE
    } rs_state_t;
endpackage

// File: rtl/rs_line_sync.sv
module rs_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);
    logic [LINES-1:0] stage_q [STAGES];

    // Each stage resets to the idle (released, high) bus level.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '1;
                else        stage_q[s] <= raw_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '1;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/rs_baud.sv
module rs_baud #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] reload_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;
    logic         run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= reload_i;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = run_q && (cnt_q == '0);

    // R3: expiry is a single-cycle pulse unless the counter is reloaded
    assert_expire_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o && !load_i |=> !expire_o);

    // R3: a running counter steps down by one per cycle
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && (cnt_q != '0) && !load_i |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
    import i2c_rs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic bus_active_i,
    input  logic scl_s_i,
    input  logic sda_s_i,
    input  logic expire_i,
    output logic load_o,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic busy_o,
    output logic start_seen_o,
    output logic done_irq_o,
    output logic collision_o
);
    rs_state_t state_q, state_d;
    logic accept, coll_evt;
    logic sda_hold_q, start_q, coll_q, sda_prev_q;

    // Next-state and event decode
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        coll_evt = 1'b0;
        load_o   = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                if (req_i && !bus_active_i) begin
                    state_d = RS_SCL_DOWN;
                    accept  = 1'b1;
                end
            end
            RS_SCL_DOWN: begin
                if (!scl_s_i) begin
                    state_d = RS_SDA_UP;
                    load_o  = 1'b1;
                end
            end
            RS_SDA_UP: begin
                if (expire_i) state_d = sda_s_i ? RS_SCL_UP : RS_SDA_WAIT;
            end
            RS_SDA_WAIT: begin
                if (sda_s_i) state_d = RS_SCL_UP;
            end
            RS_SCL_UP: begin
                if (scl_s_i) begin
                    if (!sda_s_i) begin
                        coll_evt = 1'b1;
                        state_d  = RS_IDLE;
                    end else begin
                        state_d = RS_HOLD_HIGH;
                        load_o  = 1'b1;
                    end
                end
            end
            RS_HOLD_HIGH: begin
                if (!scl_s_i) begin
                    coll_evt = 1'b1;
                    state_d  = RS_IDLE;
                end else if (expire_i) begin
                    state_d = RS_SDA_DOWN;
                    load_o  = 1'b1;
                end
            end
            RS_SDA_DOWN: begin
                if (expire_i) state_d = RS_DONE;
            end
            RS_DONE: state_d = RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    // State register and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= RS_IDLE;
            sda_hold_q <= 1'b0;
            start_q    <= 1'b0;
            coll_q     <= 1'b0;
            sda_prev_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            sda_prev_q <= sda_s_i;
            if (coll_evt)
                sda_hold_q <= 1'b0;
            else if (state_d == RS_DONE)
                sda_hold_q <= 1'b1;
            else if (state_q == RS_SCL_DOWN && state_d == RS_SDA_UP)
                sda_hold_q <= 1'b0;
            if (accept)
                start_q <= 1'b0;
            else if (scl_s_i && sda_prev_q && !sda_s_i)
                start_q <= 1'b1;
            if (accept)
                coll_q <= 1'b0;
            else if (coll_evt)
                coll_q <= 1'b1;
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        scl_pull_o = 1'b0;
        sda_pull_o = 1'b0;
        unique case (state_q)
            RS_IDLE:      sda_pull_o = sda_hold_q;
            RS_SCL_DOWN: begin
                scl_pull_o = 1'b1;
                sda_pull_o = sda_hold_q;
            end
            RS_SDA_UP:    scl_pull_o = 1'b1;
            RS_SDA_WAIT:  scl_pull_o = 1'b1;
            RS_SCL_UP:    ;
            RS_HOLD_HIGH: ;
            RS_SDA_DOWN:  sda_pull_o = 1'b1;
            RS_DONE:      sda_pull_o = 1'b1;
            default:      ;
        endcase
        busy_o       = (state_q != RS_IDLE);
        done_irq_o   = (state_q == RS_DONE);
        start_seen_o = start_q;
        collision_o  = coll_q;
    end

    // R1: an idle block with another event active stays idle
    assert_ignore_when_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && bus_active_i |=> !busy_o);

    // R2: acceptance pulls the clock first and leaves the data line as it was
    assert_scl_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> scl_pull_o && (sda_pull_o == $past(sda_pull_o)));

    // R4: the data line is pulled low only while the clock is sampled high
    assert_sda_fall_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) && busy_o |-> scl_s_i);

    // R5: the completion pulse lasts one cycle and ends the sequence
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |=> !done_irq_o && !busy_o);

    // R9: a collision leaves both lines released and the block idle
    assert_coll_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(collision_o) |-> !scl_pull_o && !sda_pull_o && !busy_o && !done_irq_o);
endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq #(
    parameter int BRG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rs_req_i,
    input  logic             bus_active_i,
    input  logic [BRG_W-1:0] reload_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_pull_o,
    output logic             sda_pull_o,
    output logic             busy_o,
    output logic             start_seen_o,
    output logic             done_irq_o,
    output logic             collision_o
);
    localparam int LINES   = 2;
    localparam int SCL_BIT = 0;
    localparam int SDA_BIT = 1;

    logic [LINES-1:0] lines_s;
    logic             brg_load, brg_expire;

    rs_line_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .sync_o (lines_s)
    );

    rs_baud #(.W(BRG_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (brg_load),
        .reload_i (reload_i),
        .expire_o (brg_expire)
    );

    rs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (rs_req_i),
        .bus_active_i (bus_active_i),
        .scl_s_i      (lines_s[SCL_BIT]),
        .sda_s_i      (lines_s[SDA_BIT]),
        .expire_i     (brg_expire),
        .load_o       (brg_load),
        .scl_pull_o   (scl_pull_o),
        .sda_pull_o   (sda_pull_o),
        .busy_o       (busy_o),
        .start_seen_o (start_seen_o),
        .done_irq_o   (done_irq_o),
        .collision_o  (collision_o)
    );
endmodule

// File: tb/i2c_rstart_seq_tb.sv
`timescale 1ns/1ps
module i2c_rstart_seq_tb;
    localparam int BRG_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rs_req_i = 1'b0;
    logic bus_active_i = 1'b0;
    logic [BRG_W-1:0] reload_i = '0;
    logic ext_scl_low = 1'b0;
    logic ext_sda_low = 1'b0;
    logic scl_i, sda_i;
    logic scl_pull_o, sda_pull_o, busy_o, start_seen_o, done_irq_o, collision_o;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    // Open-drain wires: low if anyone pulls
    assign scl_i = !(scl_pull_o || ext_scl_low);
    assign sda_i = !(sda_pull_o || ext_sda_low);

    i2c_rstart_seq #(.BRG_W(BRG_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .rs_req_i(rs_req_i), .bus_active_i(bus_active_i),
        .reload_i(reload_i), .scl_i(scl_i), .sda_i(sda_i),
        .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .busy_o(busy_o),
        .start_seen_o(start_seen_o), .done_irq_o(done_irq_o), .collision_o(collision_o)
    );

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (done_irq_o) done_cnt++;
        if (cyc == 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung act=%0d exp=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req();
        @(negedge clk);
        rs_req_i = 1'b1;
        @(negedge clk);
        rs_req_i = 1'b0;
    endtask

    task automatic wait_scl_released();
        while (scl_pull_o !== 1'b0) @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R9 reset busy", busy_o, 0);
        chk("R2 reset scl_pull", scl_pull_o, 0);
        chk("R5 reset sda_pull", sda_pull_o, 0);
        chk("R5 reset done", done_irq_o, 0);
        chk("R9 reset collision", collision_o, 0);
        chk("R6 reset start_seen", start_seen_o, 0);
    endtask

    // R1: request blocked by another bus event
    task automatic test_ignore_active();
        bus_active_i = 1'b1;
        pulse_req();
        chk("R1 blocked busy", busy_o, 0);
        chk("R1 blocked scl_pull", scl_pull_o, 0);
        bus_active_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 not remembered", busy_o, 0);
    endtask

    task automatic run_normal(input int rl, input int hold);
        int n;
        reload_i = rl[BRG_W-1:0];
        pulse_req();
        chk("R2 scl pulled first", scl_pull_o, 1);
        chk("R2 sda unchanged", sda_pull_o, hold);
        chk("R9 collision cleared", collision_o, 0);
        chk("R6 start cleared", start_seen_o, 0);
        if (hold != 0) begin
            while (sda_pull_o !== 1'b0) @(negedge clk);
            n = 0;
            while (scl_pull_o !== 1'b0) begin @(negedge clk); n++; end
            chk("R3 scl low time", n, rl + 1);
        end else begin
            wait_scl_released();
        end
        n = 0;
        while (sda_pull_o !== 1'b1) begin @(negedge clk); n++; end
        chk("R4 high hold", n, rl + 4);
        n = 0;
        while (done_irq_o !== 1'b1) begin @(negedge clk); n++; end
        chk("R5 sda low time", n, rl + 1);
        chk("R6 start before done", start_seen_o, 1);
        @(negedge clk);
        chk("R5 pulse ends", done_irq_o, 0);
        chk("R5 idle after", busy_o, 0);
        chk("R5 sda stays low", sda_pull_o, 1);
        chk("R5 scl released", scl_pull_o, 0);
    endtask

    // R10: another device stretches the clock after release
    task automatic test_stretch(input int rl);
        int n;
        reload_i = rl[BRG_W-1:0];
        pulse_req();
        wait_scl_released();
        ext_scl_low = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 no collision while stretched", collision_o, 0);
        chk("R10 waiting busy", busy_o, 1);
        chk("R10 sda not pulled", sda_pull_o, 0);
        ext_scl_low = 1'b0;
        n = 0;
        while (sda_pull_o !== 1'b1) begin @(negedge clk); n++; end
        chk("R10 timing from release", n, rl + 4);
        while (done_irq_o !== 1'b1) @(negedge clk);
        chk("R10 finished clean", collision_o, 0);
        @(negedge clk);
    endtask

    // R1: request while busy is dropped
    task automatic test_req_while_busy(input int rl);
        int d0;
        d0 = done_cnt;
        reload_i = rl[BRG_W-1:0];
        pulse_req();
        wait_scl_released();
        pulse_req();
        while (done_irq_o !== 1'b1) @(negedge clk);
        repeat (10) @(negedge clk);
        chk("R1 single completion", done_cnt, d0 + 1);
        chk("R1 no second run", busy_o, 0);
    endtask

    // R7: data line low as clock rises
    task automatic test_coll_sda(input int rl);
        int d0;
        d0 = done_cnt;
        reload_i = rl[BRG_W-1:0];
        pulse_req();
        wait_scl_released();
        ext_sda_low = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 collision set", collision_o, 1);
        chk("R9 idle", busy_o, 0);
        chk("R9 scl released", scl_pull_o, 0);
        chk("R9 sda released", sda_pull_o, 0);
        ext_sda_low = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 no done", done_cnt, d0);
        chk("R9 sticky", collision_o, 1);
    endtask

    // R8: clock pulled low during high hold
    task automatic test_coll_scl(input int rl);
        int d0;
        d0 = done_cnt;
        reload_i = rl[BRG_W-1:0];
        pulse_req();
        wait_scl_released();
        repeat (6) @(negedge clk);
        chk("R8 no early collision", collision_o, 0);
        ext_scl_low = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 collision set", collision_o, 1);
        chk("R9 sda released", sda_pull_o, 0);
        chk("R9 idle", busy_o, 0);
        ext_scl_low = 1'b0;
        repeat (30) @(negedge clk);
        chk("R9 no done", done_cnt, d0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_ignore_active();
        run_normal(3, 0);
        run_normal(7, 1);
        test_stretch(4);
        test_req_while_busy(5);
        test_coll_sda(3);
        test_coll_scl(20);
        run_normal(4, 0);
        summary();
        $finish;
    end
endmodule